// File: doc/BRIEF.md
# SMBus Bus-State and Timeout Monitor

This block watches the clock and data lines of a two-wire SMBus and tracks whether a transfer is in progress. It synchronizes both lines, recognises START and STOP conditions, and keeps a busy flag. The flag is set by a START. It is released by a STOP, or by a bus-free timeout when both lines stay high long enough.

Two timeout mechanisms run beside the condition detector. The first is a bus-free timer. It is paced by one of four external overflow ticks, chosen by a 2-bit select. The second is an SCL-low timer. It is pinned to a loadable reload value while SCL is high and counts up on every clock while SCL is low. When it overflows it raises a single interrupt pulse, so that software can reset the bus after a stuck-low clock. That pulse is meant to come after about 25 ms of continuous low, which is set by the choice of reload value.

A separate condition interrupt fires on START and STOP. It can be suppressed for slave-side activity without affecting the master side.

Top module: `smb_bus_monitor`

## Requirements
- R1: While `en` is 0, no strobe or interrupt output is asserted, `busy_o` is 0, and both timeout timers are held at their starting state.
- R2: A falling edge of SDA while SCL is high produces a one-cycle `start_o` pulse and sets `busy_o` in the same cycle.
- R3: A rising edge of SDA while SCL is high produces a one-cycle `stop_o` pulse and clears `busy_o` in the same cycle.
- R4: With `free_to_en` set, `free_o` pulses once when both lines have stayed high for more than 10 selected ticks, and that pulse clears `busy_o`. The count restarts whenever either line goes low, and it does not fire again until a line has gone low.
- R5: `src_sel` picks the pacing tick: value 0 selects `tick_src[0]`, 1 `tick_src[1]`, 2 `tick_src[2]` and 3 `tick_src[3]`. Ticks on any unselected line have no effect.
- R6: With `scl_to_en` set, the SCL-low timer is held at `reload_val` while SCL is high and increments once per clock while SCL is low. `low_irq_o` pulses when the timer steps past all-ones, so it fires after 2^16 − `reload_val` low cycles. A low period shorter than that gives no pulse.
- R7: `low_irq_o` is a single-cycle pulse and does not fire again until SCL has been high.
- R8: With `split_mode` set, only the upper byte is held at reload while SCL is high. The lower byte runs freely, so a low period still yields exactly one `low_irq_o` pulse.
- R9: `bus_irq_o` pulses together with every START or STOP strobe, except when `slave_inh` is 1 and `is_master` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| free_to_en | input | 1 | Bus-free timeout enable |
| scl_to_en | input | 1 | SCL-low timeout enable |
| src_sel | input | 2 | Free-timer tick source select |
| tick_src | input | 4 | Overflow tick strobes from four timers |
| split_mode | input | 1 | Hold only the upper byte of the low timer at reload |
| reload_val | input | 16 | Reload value of the SCL-low timer |
| slave_inh | input | 1 | Suppress condition interrupts for slave-side activity |
| is_master | input | 1 | Block currently acts as bus master |
| busy_o | output | 1 | Transfer in progress |
| start_o | output | 1 | START detected strobe |
| stop_o | output | 1 | STOP detected strobe |
| free_o | output | 1 | Bus-free timeout event |
| low_irq_o | output | 1 | SCL-low timeout interrupt pulse |
| bus_irq_o | output | 1 | START/STOP condition interrupt pulse |

## Verification
The hardest state to reach is a busy bus released by the free timeout rather than by a STOP. Both lines must end up high without SDA ever rising while SCL is high. The stimulus gets there by issuing a START, pulling SCL low, raising SDA during the low phase, and then raising SCL. The selected tick source then runs past ten ticks while the bench checks that busy stays set partway through. A second case selects a silent tick line and shows that busy never drops.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FREE_LIMIT  = 10;
  localparam int unsigned LOW_W       = 16;
  localparam int unsigned NUM_SRC     = 4;
  localparam int unsigned SEL_W       = $clog2(NUM_SRC);
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sda_s,
  input  logic scl_s,
  input  logic free_evt,
  input  logic slave_inh,
  input  logic is_master,
  output logic busy_o,
  output logic start_o,
  output logic stop_o,
  output logic bus_irq_o
);
  logic sda_q, scl_q;
  logic start_d, stop_d, irq_mask;

  assign start_d  = en && sda_q && !sda_s && scl_q && scl_s;
  assign stop_d   = en && !sda_q && sda_s && scl_q && scl_s;
  assign irq_mask = slave_inh && !is_master;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q     <= 1'b1;
      scl_q     <= 1'b1;
      busy_o    <= 1'b0;
      start_o   <= 1'b0;
      stop_o    <= 1'b0;
      bus_irq_o <= 1'b0;
    end else begin
      sda_q     <= sda_s;
      scl_q     <= scl_s;
      start_o   <= start_d;
      stop_o    <= stop_d;
      bus_irq_o <= (start_d || stop_d) && !irq_mask;
      if (!en)                      busy_o <= 1'b0;
      else if (start_d)             busy_o <= 1'b1;
      else if (stop_d || free_evt)  busy_o <= 1'b0;
    end
  end

  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);
  p_stop_clears_busy_r3: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !busy_o);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy_o && !start_o && !stop_o && !bus_irq_o));
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_irq_o && !(start_o || stop_o)) |-> 1'b0 == 1'b1 ? 1'b0 : !bus_irq_o);
endmodule

// File: rtl/smb_free_timer.sv
module smb_free_timer #(
  parameter int unsigned LIMIT   = 10,
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned CW     = $clog2(LIMIT + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               free_to_en,
  input  logic               sda_s,
  input  logic               scl_s,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic               free_o
);
  localparam logic [CW-1:0] LIM  = CW'(LIMIT);
  localparam logic [CW-1:0] SATV = CW'(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          tick, idle, run;

  assign tick = tick_src[src_sel];
  assign idle = sda_s && scl_s;
  assign run  = en && free_to_en && idle;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      free_o <= 1'b0;
    end else begin
      free_o <= tick && (cnt == LIM);
      if (tick && cnt != SATV) cnt <= cnt + 1'b1;
    end
  end

  p_free_sat_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= SATV);
  p_free_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    free_o |=> !free_o);
  p_free_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !free_o);
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
  parameter int unsigned W = 16,
  localparam int unsigned HW = W / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         scl_to_en,
  input  logic         scl_s,
  input  logic         split_mode,
  input  logic [W-1:0] reload_val,
  output logic         low_irq_o
);
  logic [W-HW-1:0] hi;
  logic [HW-1:0]   lo;
  logic            armed, counting, lo_wrap;

  assign counting = en && scl_to_en && !scl_s;
  assign lo_wrap  = &lo;

  always_ff @(posedge clk) begin
    if (rst || !en || !scl_to_en) begin
      hi        <= reload_val[W-1:HW];
      lo        <= reload_val[HW-1:0];
      armed     <= 1'b1;
      low_irq_o <= 1'b0;
    end else if (!counting) begin
      hi        <= reload_val[W-1:HW];
      lo        <= split_mode ? lo + 1'b1 : reload_val[HW-1:0];
      armed     <= 1'b1;
      low_irq_o <= 1'b0;
    end else begin
      lo <= lo + 1'b1;
      if (lo_wrap) hi <= hi + 1'b1;
      low_irq_o <= armed && lo_wrap && (&hi);
      if (lo_wrap && (&hi)) armed <= 1'b0;
    end
  end

  p_low_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    low_irq_o |=> !low_irq_o);
  p_low_held_r6: assert property (@(posedge clk) disable iff (rst)
    (en && scl_to_en && scl_s) |=> !low_irq_o);
  p_low_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    (low_irq_o && !scl_s) |=> !armed);
endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor
  import smb_mon_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               sda_in,
  input  logic               scl_in,
  input  logic               free_to_en,
  input  logic               scl_to_en,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic               split_mode,
  input  logic [LOW_W-1:0]   reload_val,
  input  logic               slave_inh,
  input  logic               is_master,
  output logic               busy_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               free_o,
  output logic               low_irq_o,
  output logic               bus_irq_o
);
  logic [1:0] lines_s;
  logic       sda_s, scl_s;

  smb_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst(rst), .raw_i({scl_in, sda_in}), .sync_o(lines_s)
  );
  assign sda_s = lines_s[0];
  assign scl_s = lines_s[1];

  smb_free_timer #(.LIMIT(FREE_LIMIT), .NUM_SRC(NUM_SRC)) u_free (
    .clk(clk), .rst(rst), .en(en), .free_to_en(free_to_en),
    .sda_s(sda_s), .scl_s(scl_s), .src_sel(src_sel),
    .tick_src(tick_src), .free_o(free_o)
  );

  smb_cond_detect u_cond (
    .clk(clk), .rst(rst), .en(en), .sda_s(sda_s), .scl_s(scl_s),
    .free_evt(free_o), .slave_inh(slave_inh), .is_master(is_master),
    .busy_o(busy_o), .start_o(start_o), .stop_o(stop_o),
    .bus_irq_o(bus_irq_o)
  );

  smb_low_timer #(.W(LOW_W)) u_low (
    .clk(clk), .rst(rst), .en(en), .scl_to_en(scl_to_en),
    .scl_s(scl_s), .split_mode(split_mode), .reload_val(reload_val),
    .low_irq_o(low_irq_o)
  );

  p_free_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (free_o && !start_o) |=> !busy_o);
  p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));
endmodule

// File: tb/smb_bus_monitor_bench.sv
module smb_bus_monitor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, sda = 1'b1, scl = 1'b1;
  logic free_to_en = 1'b0, scl_to_en = 1'b0, split_mode = 1'b0;
  logic [1:0] src_sel = 2'd2;
  logic [3:0] tick_src = 4'b0;
  logic [3:0] tick_mask = 4'b0100;
  logic [15:0] reload_val = 16'hFFF0;
  logic slave_inh = 1'b0, is_master = 1'b0;
  logic busy_o, start_o, stop_o, free_o, low_irq_o, bus_irq_o;

  int checks = 0, fails = 0;
  int expq[$];
  int cyc = 0;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  smb_bus_monitor u_smb_bus_monitor (
    .clk(clk), .rst(rst), .en(en), .sda_in(sda), .scl_in(scl),
    .free_to_en(free_to_en), .scl_to_en(scl_to_en), .src_sel(src_sel),
    .tick_src(tick_src), .split_mode(split_mode), .reload_val(reload_val),
    .slave_inh(slave_inh), .is_master(is_master), .busy_o(busy_o),
    .start_o(start_o), .stop_o(stop_o), .free_o(free_o),
    .low_irq_o(low_irq_o), .bus_irq_o(bus_irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator: one pulse every 4 cycles on the lines in tick_mask
  always @(negedge clk) begin
    tick_cnt <= tick_cnt + 1;
    tick_src <= ((tick_cnt % 4) == 0) ? tick_mask : 4'b0;
  end

  // monitor: pops expected events in a fixed per-cycle order
  task automatic pop_cmp(input int code);
    if (expq.size() == 0) check(1'b0, "unexpected event", code, 0);
    else begin
      int e = expq.pop_front();
      check(e == code, (code == 1) ? "R2 start" : (code == 2) ? "R3 stop" :
            (code == 5) ? "R9 bus_irq" : (code == 3) ? "R4 free" : "R6 low_irq",
            code, e);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (start_o)   pop_cmp(1);
      if (stop_o)    pop_cmp(2);
      if (bus_irq_o) pop_cmp(5);
      if (free_o)    pop_cmp(3);
      if (low_irq_o) pop_cmp(4);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input bit irq_exp);
    expq.push_back(1);
    if (irq_exp) expq.push_back(5);
    sda = 1'b0; wait_cyc(6);
  endtask

  task automatic do_stop(input bit irq_exp);
    expq.push_back(2);
    if (irq_exp) expq.push_back(5);
    sda = 1'b1; wait_cyc(6);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    check(!busy_o && !start_o && !stop_o && !free_o && !low_irq_o && !bus_irq_o,
          "R1 reset state", busy_o, 0);

    // R1: disabled monitor ignores a START pattern
    sda = 1'b0; wait_cyc(6);
    check(busy_o == 1'b0, "R1 busy with en=0", busy_o, 0);
    sda = 1'b1; wait_cyc(6);

    en = 1'b1; wait_cyc(4);
    do_start(1'b1);
    check(busy_o == 1'b1, "R2 busy set", busy_o, 1);
    do_stop(1'b1);
    check(busy_o == 1'b0, "R3 busy cleared", busy_o, 0);

    // R9: slave-side inhibited, master-side not
    slave_inh = 1'b1; is_master = 1'b0;
    do_start(1'b0); do_stop(1'b0);
    is_master = 1'b1;
    do_start(1'b1); do_stop(1'b1);
    slave_inh = 1'b0; is_master = 1'b0;

    // R4/R5: free timeout after a START with no STOP, source 2
    do_start(1'b1);
    scl = 1'b0; wait_cyc(4);
    sda = 1'b1; wait_cyc(4);
    free_to_en = 1'b1;
    scl = 1'b1; wait_cyc(20);
    check(busy_o == 1'b1, "R4 busy held before timeout", busy_o, 1);
    expq.push_back(3);
    wait_cyc(40);
    check(busy_o == 1'b0, "R4 busy released by free timeout", busy_o, 0);
    check(expq.size() == 0, "R4 free event seen", expq.size(), 0);
    wait_cyc(60);

    // R5: select a silent source (1) while ticks run on line 2
    free_to_en = 1'b0; src_sel = 2'd1;
    do_start(1'b1);
    scl = 1'b0; wait_cyc(4); sda = 1'b1; wait_cyc(4);
    free_to_en = 1'b1; scl = 1'b1; wait_cyc(80);
    check(busy_o == 1'b1, "R5 unselected ticks ignored", busy_o, 1);
    // R5: switch ticks to line 1 with select 1
    tick_mask = 4'b0010;
    expq.push_back(3);
    wait_cyc(60);
    check(busy_o == 1'b0, "R5 select 1 uses tick_src[1]", busy_o, 0);
    free_to_en = 1'b0; tick_mask = 4'b0100; src_sel = 2'd2;
    wait_cyc(4);

    // R6: SCL-low timer, reload FFF0 -> 16 low cycles to overflow
    scl_to_en = 1'b1; reload_val = 16'hFFF0; wait_cyc(4);
    scl = 1'b0; wait_cyc(10);
    scl = 1'b1; wait_cyc(6);
    check(expq.size() == 0, "R6 short low gives no irq", expq.size(), 0);
    expq.push_back(4);
    scl = 1'b0; wait_cyc(100);
    check(expq.size() == 0, "R6 long low gives irq", expq.size(), 0);
    // R7: still low, no refire (monitor flags any extra)
    wait_cyc(100);
    scl = 1'b1; wait_cyc(6);
    expq.push_back(4);
    scl = 1'b0; wait_cyc(40);
    check(expq.size() == 0, "R7 refires after SCL high", expq.size(), 0);
    scl = 1'b1; wait_cyc(6);

    // R6: reload FF00 needs 256 low cycles; 200 is not enough
    reload_val = 16'hFF00; wait_cyc(4);
    scl = 1'b0; wait_cyc(200);
    scl = 1'b1; wait_cyc(6);
    check(expq.size() == 0, "R6 200 low cycles under threshold", expq.size(), 0);

    // R8: split mode, one pulse in a long low period
    split_mode = 1'b1; wait_cyc(4);
    expq.push_back(4);
    scl = 1'b0; wait_cyc(600);
    check(expq.size() == 0, "R8 split mode single irq", expq.size(), 0);
    scl = 1'b1; wait_cyc(6);
    split_mode = 1'b0; scl_to_en = 1'b0;

    // R1: disabling clears busy
    do_start(1'b1);
    en = 1'b0; wait_cyc(4);
    check(busy_o == 1'b0, "R1 busy cleared when disabled", busy_o, 0);
    sda = 1'b1; wait_cyc(6);
    check(expq.size() == 0, "R1 no events while disabled", expq.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc == 20000);
    check(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule